// File: doc/BRIEF.md
# Calibration Pulse Command Generator

This block is the digital control core of a charge-injection calibration pulser. A simple register bus loads three kinds of setting: an 18-bit word for the pulse-height DAC, a 96-bit mask that turns individual current outputs on or off, and one 8-bit delay for each of six command lines. The six command lines form three pairs. Line pairing does not change their behaviour.

A fire request starts one pulse sequence. Each command line counts its own delay in clock ticks and then drives a pulse of fixed length. The downstream fanouts open their switches on the rising edge of that pulse, so the block's main duty is to place each edge on the exact tick that was programmed. A fire request that arrives while a sequence is still running is dropped, and a sticky flag records the drop.

Enable and delay writes are accepted at any time. They go into shadow storage, so a running sequence always keeps the mask and timing it started with. New values apply once the sequence has ended.

Top module: `calpulse_cmdgen`

## Requirements
- R1: After reset the DAC word, the enable mask, all command lines, all delays, `busy_o` and the dropped-fire flag are zero.
- R2: A write to address 0 loads bits [17:0] of the write data into the DAC word. `dac_o` shows the new value from the clock edge of the write, and a read of address 0 returns it zero-extended.
- R3: Addresses 1, 2 and 3 each hold 32 enable bits. A write to address 1+k sets `en_o[32k+31:32k]`. While no sequence is running, `en_o` shows the new bits from the clock edge of the write.
- R4: Address 4+c holds the delay of command line c in bits [7:0]. A read returns the last value written, even while a sequence is running.
- R5: A fire request sampled at clock edge F with `busy_o` low makes command line c rise at edge F+1+d. Here d is the delay value held for that line at edge F, so d=0 gives a rise on the very next edge and d=255 gives a rise 255 edges after that.
- R6: Every command pulse stays high for exactly 16 clock cycles.
- R7: Command lines are independent. Each one follows only its own delay, lines with equal delays pulse together, and no line produces an edge without a fire request.
- R8: A fire request sampled while `busy_o` is high is ignored. It adds no command edges and sets the dropped-fire flag, which reads as bit 1 of address 10. Bit 0 of address 10 reads `busy_o`.
- R9: Writes to enable or delay registers made during a sequence do not change `en_o` or the timing of that sequence. Once `busy_o` falls, `en_o` shows the new mask and the next fire uses the new delays.
- R10: A write to address 10 with bit 1 set clears the dropped-fire flag. If a fire is dropped in the same cycle, the flag stays set.
- R11: `busy_o` rises on the edge that accepts a fire request. It stays high while any command line is still waiting or pulsing, so it falls on the edge where the last pulse ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Timing tick; one tick is one delay step |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bus_we_i | input | 1 | Register write strobe |
| bus_addr_i | input | 4 | Register address |
| bus_wdata_i | input | 32 | Register write data |
| bus_rdata_o | output | 32 | Combinational read data for `bus_addr_i` |
| fire_i | input | 1 | Fire request, sampled on the clock edge |
| cmd_o | output | 6 | Command pulses; lines 2p and 2p+1 form pair p |
| en_o | output | 96 | Current-enable mask in effect |
| dac_o | output | 18 | Pulse-height DAC word |
| busy_o | output | 1 | A pulse sequence is in progress |

## Verification
The bench targets these corner cases:

- **Both ends of the delay range (0 and 255).** A counter that is off by one would shift the edge by one tick, and the scoreboard would report it at the exact cycle.
- **Fire requests during a running sequence.** A design that restarted the sequence would emit extra edges, and a design that forgot to record the drop would leave the status flag clear.
- **Mask and delay writes in the middle of a sequence.** A design without shadowing would change `en_o` during the pulses or move the next edges, and a design that lost the held value would never apply the new settings afterwards.
- **All lines set to the same delay.** A design that serialised the lines would stagger the edges.

// File: rtl/calpulse_pkg.sv
package calpulse_pkg;

   typedef enum logic [1:0] {
      CH_IDLE  = 2'd0,
      CH_WAIT  = 2'd1,
      CH_PULSE = 2'd2
   } ch_state_e;

   localparam int STAT_BUSY_BIT = 0;
   localparam int STAT_DROP_BIT = 1;

endpackage

// File: rtl/calpulse_chan.sv
module calpulse_chan
   import calpulse_pkg::*;
#(
   parameter int DLY_W = 8,
   parameter int PW    = 16
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             start_i,
   input  logic [DLY_W-1:0] dly_i,
   output logic             cmd_o,
   output logic             active_o
);

   localparam int PW_W  = (PW > 1) ? $clog2(PW) : 1;
   localparam int CNT_W = (DLY_W > PW_W) ? DLY_W : PW_W;

   ch_state_e        state_q;
   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         state_q <= CH_IDLE;
         cnt_q   <= '0;
      end else begin
         unique case (state_q)
            CH_IDLE: begin
               if (start_i) begin
                  state_q <= CH_WAIT;
                  cnt_q   <= CNT_W'(dly_i);
               end
            end
            CH_WAIT: begin
               if (cnt_q == '0) begin
                  state_q <= CH_PULSE;
                  cnt_q   <= CNT_W'(PW - 1);
               end else begin
                  cnt_q <= cnt_q - 1'b1;
               end
            end
            CH_PULSE: begin
               if (cnt_q == '0) begin
                  state_q <= CH_IDLE;
               end else begin
                  cnt_q <= cnt_q - 1'b1;
               end
            end
            default: state_q <= CH_IDLE;
         endcase
      end
   end

   assign cmd_o    = (state_q == CH_PULSE);
   assign active_o = (state_q != CH_IDLE);

endmodule

// File: rtl/calpulse_regs.sv
module calpulse_regs
   import calpulse_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int ADDR_W = 4,
   parameter int DAC_W  = 18,
   parameter int N_EN   = 96,
   parameter int N_CMD  = 6,
   parameter int DLY_W  = 8
) (
   input  logic                         clk_i,
   input  logic                         rst_ni,
   input  logic                         we_i,
   input  logic [ADDR_W-1:0]            addr_i,
   input  logic [DATA_W-1:0]            wdata_i,
   output logic [DATA_W-1:0]            rdata_o,
   input  logic                         busy_i,
   input  logic                         start_i,
   input  logic                         drop_i,
   output logic [DAC_W-1:0]             dac_o,
   output logic [N_EN-1:0]              en_o,
   output logic [N_CMD-1:0][DLY_W-1:0]  dly_o,
   output logic                         drop_flag_o
);

   localparam int EN_WORDS = N_EN / DATA_W;
   localparam int A_DAC    = 0;
   localparam int A_EN0    = A_DAC + 1;
   localparam int A_DLY0   = A_EN0 + EN_WORDS;
   localparam int A_STAT   = A_DLY0 + N_CMD;

   logic [DAC_W-1:0]            dac_q;
   logic [N_EN-1:0]             en_sh_q;
   logic [N_EN-1:0]             en_hold_q;
   logic [N_CMD-1:0][DLY_W-1:0] dly_sh_q;
   logic                        drop_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         dac_q <= '0;
      end else if (we_i && addr_i == ADDR_W'(A_DAC)) begin
         dac_q <= wdata_i[DAC_W-1:0];
      end
   end

   for (genvar w = 0; w < EN_WORDS; w++) begin : g_en_word
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) begin
            en_sh_q[w*DATA_W +: DATA_W] <= '0;
         end else if (we_i && addr_i == ADDR_W'(A_EN0 + w)) begin
            en_sh_q[w*DATA_W +: DATA_W] <= wdata_i;
         end
      end
   end

   for (genvar c = 0; c < N_CMD; c++) begin : g_dly
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) begin
            dly_sh_q[c] <= '0;
         end else if (we_i && addr_i == ADDR_W'(A_DLY0 + c)) begin
            dly_sh_q[c] <= wdata_i[DLY_W-1:0];
         end
      end
   end

   // Mask copy frozen for the length of a sequence.
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         en_hold_q <= '0;
      end else if (start_i) begin
         en_hold_q <= en_sh_q;
      end
   end

   // Dropped-fire flag: setting beats clearing.
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         drop_q <= 1'b0;
      end else if (drop_i) begin
         drop_q <= 1'b1;
      end else if (we_i && addr_i == ADDR_W'(A_STAT) && wdata_i[STAT_DROP_BIT]) begin
         drop_q <= 1'b0;
      end
   end

   always_comb begin
      rdata_o = '0;
      if (addr_i == ADDR_W'(A_DAC)) begin
         rdata_o[DAC_W-1:0] = dac_q;
      end
      for (int w = 0; w < EN_WORDS; w++) begin
         if (addr_i == ADDR_W'(A_EN0 + w)) begin
            rdata_o = en_sh_q[w*DATA_W +: DATA_W];
         end
      end
      for (int c = 0; c < N_CMD; c++) begin
         if (addr_i == ADDR_W'(A_DLY0 + c)) begin
            rdata_o[DLY_W-1:0] = dly_sh_q[c];
         end
      end
      if (addr_i == ADDR_W'(A_STAT)) begin
         rdata_o[STAT_BUSY_BIT] = busy_i;
         rdata_o[STAT_DROP_BIT] = drop_q;
      end
   end

   assign dac_o       = dac_q;
   assign en_o        = busy_i ? en_hold_q : en_sh_q;
   assign dly_o       = dly_sh_q;
   assign drop_flag_o = drop_q;

endmodule

// File: rtl/calpulse_cmdgen.sv
module calpulse_cmdgen
   import calpulse_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int ADDR_W = 4,
   parameter int DAC_W  = 18,
   parameter int N_EN   = 96,
   parameter int N_CMD  = 6,
   parameter int DLY_W  = 8,
   parameter int PW     = 16
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              bus_we_i,
   input  logic [ADDR_W-1:0] bus_addr_i,
   input  logic [DATA_W-1:0] bus_wdata_i,
   output logic [DATA_W-1:0] bus_rdata_o,
   input  logic              fire_i,
   output logic [N_CMD-1:0]  cmd_o,
   output logic [N_EN-1:0]   en_o,
   output logic [DAC_W-1:0]  dac_o,
   output logic              busy_o
);

   localparam int EN_WORDS = N_EN / DATA_W;
   localparam int N_REGS   = 2 + EN_WORDS + N_CMD;

   if (N_EN % DATA_W != 0) begin : g_bad_en
      $error("N_EN must be a multiple of DATA_W");
   end
   if (DAC_W > DATA_W || DLY_W > DATA_W || DATA_W < 2) begin : g_bad_w
      $error("DAC_W and DLY_W must fit in DATA_W");
   end
   if (N_REGS > 2**ADDR_W) begin : g_bad_addr
      $error("register map does not fit ADDR_W");
   end
   if (PW < 1) begin : g_bad_pw
      $error("PW must be at least 1");
   end

   logic [N_CMD-1:0]            active_w;
   logic [N_CMD-1:0][DLY_W-1:0] dly_w;
   logic                        start_w;
   logic                        drop_w;
   logic                        drop_flag_w;

   assign busy_o  = |active_w;
   assign start_w = fire_i & ~busy_o;
   assign drop_w  = fire_i & busy_o;

   calpulse_regs #(
      .DATA_W(DATA_W), .ADDR_W(ADDR_W), .DAC_W(DAC_W),
      .N_EN(N_EN), .N_CMD(N_CMD), .DLY_W(DLY_W)
   ) i_regs (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .we_i        (bus_we_i),
      .addr_i      (bus_addr_i),
      .wdata_i     (bus_wdata_i),
      .rdata_o     (bus_rdata_o),
      .busy_i      (busy_o),
      .start_i     (start_w),
      .drop_i      (drop_w),
      .dac_o       (dac_o),
      .en_o        (en_o),
      .dly_o       (dly_w),
      .drop_flag_o (drop_flag_w)
   );

   for (genvar c = 0; c < N_CMD; c++) begin : g_chan
      calpulse_chan #(.DLY_W(DLY_W), .PW(PW)) i_chan (
         .clk_i    (clk_i),
         .rst_ni   (rst_ni),
         .start_i  (start_w),
         .dly_i    (dly_w[c]),
         .cmd_o    (cmd_o[c]),
         .active_o (active_w[c])
      );
   end

endmodule

// File: rtl/calpulse_chk.sv
module calpulse_chk #(
   parameter int ADDR_W = 4,
   parameter int DAC_W  = 18,
   parameter int N_EN   = 96,
   parameter int N_CMD  = 6,
   parameter int PW     = 16
) (
   input logic              clk_i,
   input logic              rst_ni,
   input logic              we_i,
   input logic [ADDR_W-1:0] addr_i,
   input logic [DAC_W-1:0]  wdata_i,
   input logic              fire_i,
   input logic              busy_i,
   input logic [N_CMD-1:0]  cmd_i,
   input logic [N_EN-1:0]   en_i,
   input logic [DAC_W-1:0]  dac_i,
   input logic              drop_flag_i
);

   localparam int CW = $clog2(PW + 1) + 1;

   a_r2_dac_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (we_i && addr_i == '0) |=> dac_i == $past(wdata_i));

   a_r11_busy_after_fire: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (fire_i && !busy_i) |=> busy_i);

   a_r11_cmd_needs_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (|cmd_i) |-> busy_i);

   a_r8_drop_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (fire_i && busy_i) |=> drop_flag_i);

   a_r9_mask_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (busy_i && $past(busy_i)) |-> $stable(en_i));

   for (genvar k = 0; k < N_CMD; k++) begin : g_width
      logic [CW-1:0] hi_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) hi_q <= '0;
         else         hi_q <= cmd_i[k] ? hi_q + 1'b1 : '0;
      end

      a_r6_pulse_width: assert property (@(posedge clk_i) disable iff (!rst_ni)
         $fell(cmd_i[k]) |-> hi_q == CW'(PW));

      a_r6_no_overlong: assert property (@(posedge clk_i) disable iff (!rst_ni)
         cmd_i[k] |-> hi_q < CW'(PW));
   end

endmodule

bind calpulse_cmdgen calpulse_chk #(
   .ADDR_W(ADDR_W), .DAC_W(DAC_W), .N_EN(N_EN), .N_CMD(N_CMD), .PW(PW)
) i_chk (
   .clk_i       (clk_i),
   .rst_ni      (rst_ni),
   .we_i        (bus_we_i),
   .addr_i      (bus_addr_i),
   .wdata_i     (bus_wdata_i[DAC_W-1:0]),
   .fire_i      (fire_i),
   .busy_i      (busy_o),
   .cmd_i       (cmd_o),
   .en_i        (en_o),
   .dac_i       (dac_o),
   .drop_flag_i (drop_flag_w)
);

// File: tb/test_calpulse_cmdgen.sv
module test_calpulse_cmdgen;
   localparam int PW = 16;
   localparam int NC = 6;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        we = 1'b0;
   logic        fire = 1'b0;
   logic [3:0]  addr = '0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic [5:0]  cmd;
   logic [95:0] en;
   logic [17:0] dac;
   logic        busy;

   always #5 clk = ~clk;

   calpulse_cmdgen i_calpulse_cmdgen (
      .clk_i(clk), .rst_ni(rst_n), .bus_we_i(we), .bus_addr_i(addr),
      .bus_wdata_i(wdata), .bus_rdata_o(rdata), .fire_i(fire),
      .cmd_o(cmd), .en_o(en), .dac_o(dac), .busy_o(busy)
   );

   int cyc = 0;
   always @(posedge clk) cyc <= cyc + 1;

   int  n_chk = 0;
   int  n_fail = 0;
   bit  done = 1'b0;
   int  dly [NC];

   typedef struct {int t; int ch; bit lvl;} ev_t;
   ev_t sb[$];

   task automatic check(string req, logic [127:0] act, logic [127:0] exp, string what);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   // Monitor: compares every observed command edge with the scoreboard.
   logic [5:0] prev = '0;
   always @(negedge clk) begin
      if (rst_n) begin
         for (int c = 0; c < NC; c++) begin
            if (cmd[c] !== prev[c]) begin
               ev_t e;
               n_chk++;
               if (sb.size() == 0) begin
                  n_fail++;
                  $display("FAIL R7/R8 unexpected edge: actual ch%0d lvl %0d cyc %0d expected none",
                           c, cmd[c], cyc);
               end else begin
                  e = sb.pop_front();
                  if (e.t != cyc || e.ch != c || e.lvl != cmd[c]) begin
                     n_fail++;
                     $display("FAIL R5/R6/R7 edge: actual ch%0d lvl %0d cyc %0d expected ch%0d lvl %0d cyc %0d",
                              c, cmd[c], cyc, e.ch, e.lvl, e.t);
                  end
               end
            end
         end
      end
      prev = cmd;
   end

   task automatic push_seq(int f);
      for (int t = f + 1; t <= f + 2 + 255 + PW; t++) begin
         for (int c = 0; c < NC; c++) begin
            if (t == f + 1 + dly[c])      sb.push_back('{t, c, 1'b1});
            if (t == f + 1 + dly[c] + PW) sb.push_back('{t, c, 1'b0});
         end
      end
   endtask

   task automatic wr(int a, logic [31:0] d);
      @(negedge clk);
      we = 1'b1; addr = 4'(a); wdata = d;
      @(negedge clk);
      we = 1'b0;
   endtask

   task automatic rd(int a, output logic [31:0] d);
      @(negedge clk);
      addr = 4'(a);
      #1 d = rdata;
   endtask

   task automatic set_dly(int c, int v);
      wr(4 + c, 32'(v));
      dly[c] = v;
   endtask

   task automatic fire_seq(bit accept);
      @(negedge clk);
      fire = 1'b1;
      if (accept) push_seq(cyc + 1);
      @(negedge clk);
      fire = 1'b0;
   endtask

   task automatic wait_idle();
      do @(negedge clk); while (busy);
      @(negedge clk);
      #1 check("R5", 128'(sb.size()), 128'd0, "pending expected edges");
   endtask

   task automatic summary();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual running expected finished");
         summary();
         $finish;
      end
   end

   initial begin
      logic [31:0] r;
      for (int c = 0; c < NC; c++) dly[c] = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      check("R1", 128'(dac), 0, "dac");
      check("R1", 128'(en), 0, "en");
      check("R1", 128'(cmd), 0, "cmd");
      check("R1", 128'(busy), 0, "busy");
      rd(4, r);  check("R1", 128'(r), 0, "delay0");
      rd(10, r); check("R1", 128'(r), 0, "status");

      // R2 DAC word, upper bits dropped
      wr(0, 32'hFFFF_FFFF);
      check("R2", 128'(dac), 128'h3FFFF, "dac mask");
      rd(0, r); check("R2", 128'(r), 128'h3FFFF, "dac readback");
      wr(0, 32'h0001_2345);
      check("R2", 128'(dac), 128'h12345, "dac value");

      // R3 enable words
      wr(1, 32'hA5A5_0001);
      wr(2, 32'h0F0F_F0F0);
      wr(3, 32'h8000_00FF);
      check("R3", 128'(en), 128'h8000_00FF_0F0F_F0F0_A5A5_0001, "en mask");

      // R4 delays, including both range ends
      set_dly(0, 0); set_dly(1, 1); set_dly(2, 5);
      set_dly(3, 17); set_dly(4, 255); set_dly(5, 3);
      rd(8, r); check("R4", 128'(r), 255, "delay4 readback");

      // R5 R6 R7 R11 sequence with mixed delays
      fire_seq(1'b1);
      check("R11", 128'(busy), 1, "busy after fire");

      // R8 fire while busy is dropped
      repeat (3) @(negedge clk);
      fire_seq(1'b0);
      rd(10, r); check("R8", 128'(r), 3, "status busy+drop");

      // R9 writes during a sequence are shadowed
      wr(2, 32'h1234_5678);
      check("R9", 128'(en), 128'h8000_00FF_0F0F_F0F0_A5A5_0001, "en frozen");
      set_dly(0, 9);
      rd(4, r); check("R4", 128'(r), 9, "shadow delay readback");
      wait_idle();
      check("R9", 128'(en), 128'h8000_00FF_1234_5678_A5A5_0001, "en after end");
      check("R11", 128'(busy), 0, "busy after end");

      // R9 next sequence uses new delay 9 on line 0
      set_dly(4, 2);
      fire_seq(1'b1);
      wait_idle();

      // R10 clear the dropped-fire flag
      wr(10, 32'h2);
      rd(10, r); check("R10", 128'(r), 0, "status after clear");

      // R7 equal delays pulse together
      for (int c = 0; c < NC; c++) set_dly(c, 4);
      fire_seq(1'b1);
      repeat (6) @(negedge clk);
      check("R7", 128'(cmd), 128'h3F, "all lines high together");
      wait_idle();

      // R5 all zero delays, then an immediate refire once idle
      for (int c = 0; c < NC; c++) set_dly(c, 0);
      fire_seq(1'b1);
      wait_idle();
      fire_seq(1'b1);
      wait_idle();
      rd(10, r); check("R8", 128'(r), 0, "no drop after idle refire");

      done = 1'b1;
      summary();
      $finish;
   end
endmodule